// File: doc/BRIEF.md
# Glottal Pulse Timer

This block paces the voiced excitation of a formant speech synthesizer. Once per audio sample, marked by a one-cycle `sample_en` strobe, it advances a counter through the current pitch period. From that counter it produces an impulse of programmable amplitude, a flag that marks the open phase of the glottal cycle, and a strobe at the first sample of each period. The strobe lets neighbouring logic change filter settings in step with the pitch. At a 12 kHz sample rate the period in samples is 12000 divided by the fundamental frequency, so jitter can be added upstream. A period input of zero means unvoiced, and the block then stays silent.

Period length, open quotient, diplophonia degree and amplitude are captured only when a period begins. Frame updates arrive every 60 samples, and any values that come in mid-period wait for the next boundary. Pulses pair up. The first pulse of each pair is pushed later within its period and reduced in level according to the diplophonia degree. The second pulse falls on the period's first sample at full level.

Top module: `glottal_pulse_timer`

## Requirements
- R1: While voicing is idle, `pulse_valid`, `open_phase` and `period_start` are all low and `pulse_amp` is 0. Voicing is idle after reset, and after a period ends while `period_in` is 0.
- R2: The state advances only on clocks where `sample_en` is high. Outputs describe the sample selected at the most recent such edge. A nonzero `period_in` seen while idle starts a period, and the outputs one clock later show its sample 0. `period_start` is high exactly on sample 0 of every period of T samples.
- R3: A latched period below 2 is treated as 2.
- R4: T, open quotient, diplophonia and amplitude are captured only at a period start. Changes in the middle of a period have no effect until the next start.
- R5: Pulses alternate between a first and a second pulse of a pair. The second pulse is on sample 0 of its period, with `pulse_amp` equal to the full amplitude. `pulse_amp` is 0 whenever `pulse_valid` is low.
- R6: The first pulse of a pair falls on sample floor(T·(100−OQ)·DI/10000) of its period. When that index is T or more, the pulse is not emitted.
- R7: The first pulse's amplitude is floor(A·(100−DI)/100).
- R8: The closed phase comes first. `open_phase` is high on the last floor(T·OQ/100) samples of each period.
- R9: Percent inputs above 100 are taken as 100.
- R10: If `period_in` drops to 0 during a period, that period still completes, and the block then goes idle. The next period after idle begins with the first pulse of a pair.
- R11: When `sample_en` is low, all outputs hold their values.
- R12: During reset, all outputs are low or 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe per audio sample |
| period_in | input | 12 | Pitch period in samples; 0 means unvoiced |
| open_pct | input | 7 | Open quotient, percent |
| diplo_pct | input | 7 | Diplophonia degree, percent |
| voice_amp | input | 16 | Linear voicing amplitude |
| period_start | output | 1 | High on the first sample of each period |
| pulse_valid | output | 1 | High on an impulse sample |
| pulse_amp | output | 16 | Impulse amplitude, 0 when no impulse |
| open_phase | output | 1 | High during the open phase |

## Verification
Every output is taken from registered state with no further register stage. Each result is therefore due exactly one clock after the rising edge that carried the sample strobe, and it then holds until the next strobed edge. The bench changes inputs on falling edges. It reads outputs at the falling edge after each strobed rising edge. Expected pulse positions, phase boundaries and levels come from the sample index counted in the bench since the start edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
   localparam int PCT_W   = 7;
   localparam int PCT_MAX = 100;
   typedef logic [PCT_W-1:0] pct_t;
   typedef enum logic {PAIR_FIRST = 1'b0, PAIR_SECOND = 1'b1} pair_e;
endpackage

// File: rtl/gpt_param_latch.sv
module gpt_param_latch
   import gpt_pkg::*;
#(
   parameter int PER_W   = 12,
   parameter int AMP_W   = 16,
   parameter int MIN_PER = 2,
   parameter bit SAT_PCT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PER_W-1:0] period_in,
   input  pct_t             open_pct,
   input  pct_t             diplo_pct,
   input  logic [AMP_W-1:0] voice_amp,
   output logic [PER_W-1:0] per_q,
   output logic [PER_W-1:0] open_len_q,
   output logic [PER_W-1:0] delay_q,
   output logic [AMP_W-1:0] amp_first_q,
   output logic [AMP_W-1:0] amp_full_q
);
   localparam int PROD_W = PER_W + 2*PCT_W;
   localparam int AMPP_W = AMP_W + PCT_W;

   pct_t             oq_c, di_c;
   logic [PER_W-1:0] per_c;
   logic [PROD_W-1:0] open_prod, delay_prod;
   logic [AMPP_W-1:0] amp_prod;

   if (SAT_PCT) begin : g_sat
      assign oq_c = (open_pct  > pct_t'(PCT_MAX)) ? pct_t'(PCT_MAX) : open_pct;
      assign di_c = (diplo_pct > pct_t'(PCT_MAX)) ? pct_t'(PCT_MAX) : diplo_pct;
   end else begin : g_raw
      assign oq_c = open_pct;
      assign di_c = diplo_pct;
   end

   assign per_c      = (period_in < PER_W'(MIN_PER)) ? PER_W'(MIN_PER) : period_in;
   assign open_prod  = PROD_W'(per_c) * PROD_W'(oq_c);
   assign delay_prod = PROD_W'(per_c) * PROD_W'(pct_t'(PCT_MAX) - oq_c) * PROD_W'(di_c);
   assign amp_prod   = AMPP_W'(voice_amp) * AMPP_W'(pct_t'(PCT_MAX) - di_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q       <= PER_W'(MIN_PER);
         open_len_q  <= '0;
         delay_q     <= '0;
         amp_first_q <= '0;
         amp_full_q  <= '0;
      end else if (load) begin
         per_q       <= per_c;
         open_len_q  <= PER_W'(open_prod / PROD_W'(PCT_MAX));
         delay_q     <= PER_W'(delay_prod / PROD_W'(PCT_MAX * PCT_MAX));
         amp_first_q <= AMP_W'(amp_prod / AMPP_W'(PCT_MAX));
         amp_full_q  <= voice_amp;
      end
   end
endmodule

// File: rtl/gpt_phase_counter.sv
module gpt_phase_counter
   import gpt_pkg::*;
#(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [PER_W-1:0] period_in,
   input  logic [PER_W-1:0] per_q,
   output logic             load,
   output logic             voiced_q,
   output logic [PER_W-1:0] cnt_q,
   output pair_e            pair_q
);
   logic at_end, boundary, want_voice;

   assign at_end     = voiced_q && (cnt_q == per_q - PER_W'(1));
   assign boundary   = !voiced_q || at_end;
   assign want_voice = (period_in != '0);
   assign load       = sample_en && boundary && want_voice;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         voiced_q <= 1'b0;
         cnt_q    <= '0;
         pair_q   <= PAIR_FIRST;
      end else if (sample_en) begin
         if (boundary) begin
            cnt_q <= '0;
            if (want_voice) begin
               voiced_q <= 1'b1;
               if (voiced_q)
                  pair_q <= (pair_q == PAIR_FIRST) ? PAIR_SECOND : PAIR_FIRST;
               else
                  pair_q <= PAIR_FIRST;
            end else begin
               voiced_q <= 1'b0;
               pair_q   <= PAIR_FIRST;
            end
         end else begin
            cnt_q <= cnt_q + PER_W'(1);
         end
      end
   end
endmodule

// File: rtl/gpt_pulse_decode.sv
module gpt_pulse_decode
   import gpt_pkg::*;
#(
   parameter int PER_W = 12,
   parameter int AMP_W = 16
) (
   input  logic             voiced,
   input  logic [PER_W-1:0] cnt,
   input  pair_e            pair,
   input  logic [PER_W-1:0] per,
   input  logic [PER_W-1:0] open_len,
   input  logic [PER_W-1:0] delay,
   input  logic [AMP_W-1:0] amp_first,
   input  logic [AMP_W-1:0] amp_full,
   output logic             period_start,
   output logic             pulse_valid,
   output logic [AMP_W-1:0] pulse_amp,
   output logic             open_phase
);
   logic [PER_W-1:0] pulse_pos;
   logic             first;

   assign first        = (pair == PAIR_FIRST);
   assign pulse_pos    = first ? delay : '0;
   assign period_start = voiced && (cnt == '0);
   assign pulse_valid  = voiced && (cnt == pulse_pos);
   assign pulse_amp    = !pulse_valid ? '0 : (first ? amp_first : amp_full);
   assign open_phase   = voiced && (cnt >= per - open_len);
endmodule

// File: rtl/glottal_pulse_timer.sv
module glottal_pulse_timer
   import gpt_pkg::*;
#(
   parameter int PER_W   = 12,
   parameter int AMP_W   = 16,
   parameter int MIN_PER = 2,
   parameter bit SAT_PCT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample_en,
   input  logic [PER_W-1:0] period_in,
   input  logic [6:0]       open_pct,
   input  logic [6:0]       diplo_pct,
   input  logic [AMP_W-1:0] voice_amp,
   output logic             period_start,
   output logic             pulse_valid,
   output logic [AMP_W-1:0] pulse_amp,
   output logic             open_phase
);
   if (PER_W < 4 || PER_W > 24) begin : g_bad_per_w
      $error("PER_W out of range");
   end
   if (AMP_W < 2 || AMP_W > 32) begin : g_bad_amp_w
      $error("AMP_W out of range");
   end
   if (MIN_PER < 2 || MIN_PER >= (1 << PER_W)) begin : g_bad_min_per
      $error("MIN_PER out of range");
   end

   logic             load_w, voiced_w;
   logic [PER_W-1:0] cnt_w, per_w, open_len_w, delay_w;
   logic [AMP_W-1:0] amp_first_w, amp_full_w;
   pair_e            pair_w;

   gpt_param_latch #(.PER_W(PER_W), .AMP_W(AMP_W), .MIN_PER(MIN_PER), .SAT_PCT(SAT_PCT)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(load_w), .period_in(period_in),
      .open_pct(pct_t'(open_pct)), .diplo_pct(pct_t'(diplo_pct)), .voice_amp(voice_amp),
      .per_q(per_w), .open_len_q(open_len_w), .delay_q(delay_w),
      .amp_first_q(amp_first_w), .amp_full_q(amp_full_w)
   );

   gpt_phase_counter #(.PER_W(PER_W)) u_count (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .period_in(period_in),
      .per_q(per_w), .load(load_w), .voiced_q(voiced_w), .cnt_q(cnt_w), .pair_q(pair_w)
   );

   gpt_pulse_decode #(.PER_W(PER_W), .AMP_W(AMP_W)) u_decode (
      .voiced(voiced_w), .cnt(cnt_w), .pair(pair_w), .per(per_w),
      .open_len(open_len_w), .delay(delay_w), .amp_first(amp_first_w), .amp_full(amp_full_w),
      .period_start(period_start), .pulse_valid(pulse_valid),
      .pulse_amp(pulse_amp), .open_phase(open_phase)
   );
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
   parameter int PER_W = 12,
   parameter int AMP_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sample_en,
   input logic             period_start,
   input logic             pulse_valid,
   input logic [AMP_W-1:0] pulse_amp,
   input logic             open_phase,
   input logic             voiced,
   input logic             load,
   input logic [PER_W-1:0] lat_per
);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !voiced |-> (!pulse_valid && !open_phase && !period_start && pulse_amp == '0));

   assert_start_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_en && period_start) |=> !period_start);

   assert_latch_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lat_per) |-> $past(load));

   assert_amp_needs_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_amp != '0) |-> pulse_valid);

   assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_en |=> $stable({period_start, pulse_valid, pulse_amp, open_phase}));
endmodule

bind glottal_pulse_timer gpt_checker #(.PER_W(PER_W), .AMP_W(AMP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .period_start(period_start),
   .pulse_valid(pulse_valid), .pulse_amp(pulse_amp), .open_phase(open_phase),
   .voiced(voiced_w), .load(load_w), .lat_per(per_w)
);

// File: tb/tb_glottal_pulse_timer.sv
module tb_glottal_pulse_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic [11:0] period_in = '0;
   logic [6:0]  open_pct = '0;
   logic [6:0]  diplo_pct = '0;
   logic [15:0] voice_amp = '0;
   logic        period_start, pulse_valid, open_phase;
   logic [15:0] pulse_amp;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   // columns: T, OQ, DI, A, first-pulse index, open length, first-pulse amplitude
   localparam int NV = 6;
   localparam int VEC [NV][7] = '{
      '{ 10,  40,   0,  1000,  0,  4,  1000},
      '{ 20,  50,  50,  2000,  5, 10,  1000},
      '{100,  30,  20,   500, 14, 30,   400},
      '{ 12,   0, 100,   777, 12,  0,     0},
      '{  7, 100,  75,   400,  0,  7,   100},
      '{ 33,  25,  10, 65535,  2,  8, 58981}
   };

   glottal_pulse_timer dut (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .period_in(period_in),
      .open_pct(open_pct), .diplo_pct(diplo_pct), .voice_amp(voice_amp),
      .period_start(period_start), .pulse_valid(pulse_valid),
      .pulse_amp(pulse_amp), .open_phase(open_phase)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         tests++;
         fails++;
         $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_idle();
      period_in = '0;
      repeat (120) tick();
   endtask

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      chk("R12 period_start", int'(period_start), 0);
      chk("R12 pulse_valid", int'(pulse_valid), 0);
      chk("R12 pulse_amp", int'(pulse_amp), 0);
      chk("R12 open_phase", int'(open_phase), 0);
      rst_n = 1'b1;
      sample_en = 1'b1;

      // R1: unvoiced input keeps everything quiet
      for (int s = 0; s < 20; s++) begin
         tick();
         chk("R1 idle outputs", int'({period_start, pulse_valid, open_phase}) + int'(pulse_amp), 0);
      end

      // vector walk: R2, R5, R6, R7, R8 over two periods each
      for (int v = 0; v < NV; v++) begin
         open_pct  = 7'(VEC[v][1]);
         diplo_pct = 7'(VEC[v][2]);
         voice_amp = 16'(VEC[v][3]);
         period_in = 12'(VEC[v][0]);
         for (int s = 0; s < 2 * VEC[v][0]; s++) begin
            int t, i, p, epv;
            tick();
            t = VEC[v][0];
            p = s / t;
            i = s % t;
            epv = (p == 0) ? int'(i == VEC[v][4]) : int'(i == 0);
            chk("R2 period_start", int'(period_start), int'(i == 0));
            chk((p == 0) ? "R6 first pulse position" : "R5 second pulse position", int'(pulse_valid), epv);
            chk((p == 0) ? "R7 first pulse level" : "R5 second pulse level", int'(pulse_amp),
                epv == 0 ? 0 : ((p == 0) ? VEC[v][6] : VEC[v][3]));
            chk("R8 open phase", int'(open_phase), int'(i >= t - VEC[v][5]));
         end
         go_idle();
      end

      // R3: period 1 runs as period 2 (OQ 50 -> open on sample 1)
      open_pct = 7'd50; diplo_pct = 7'd0; voice_amp = 16'd10;
      period_in = 12'd1;
      for (int s = 0; s < 6; s++) begin
         tick();
         chk("R3 min period start", int'(period_start), int'(s % 2 == 0));
         chk("R3 min period open", int'(open_phase), int'(s % 2 == 1));
      end
      go_idle();

      // R9: percents above 100 saturate: all open, first pulse at 0 with level 0
      open_pct = 7'd127; diplo_pct = 7'd127; voice_amp = 16'd300;
      period_in = 12'd10;
      for (int s = 0; s < 11; s++) begin
         tick();
         chk("R9 saturated open", int'(open_phase), 1);
         if (s == 0) begin
            chk("R9 first pulse valid", int'(pulse_valid), 1);
            chk("R9 first pulse level", int'(pulse_amp), 0);
         end
         if (s == 10) chk("R9 second pulse level", int'(pulse_amp), 300);
      end
      go_idle();

      // R4: mid-period change waits for the boundary
      open_pct = 7'd0; diplo_pct = 7'd0; voice_amp = 16'd50;
      period_in = 12'd20;
      for (int s = 0; s < 32; s++) begin
         tick();
         if (s == 5) begin
            period_in = 12'd10;
            voice_amp = 16'd90;
         end
         chk("R4 boundary timing", int'(period_start), int'(s == 0 || s == 20 || s == 30));
         if (s == 0)  chk("R4 old level", int'(pulse_amp), 50);
         if (s == 20) chk("R4 new level", int'(pulse_amp), 90);
      end
      go_idle();

      // R10: stop mid-period, finish it, restart with first of pair
      open_pct = 7'd0; diplo_pct = 7'd50; voice_amp = 16'd100;
      period_in = 12'd20;
      for (int s = 0; s < 26; s++) begin
         tick();
         if (s == 3) period_in = 12'd0;
         if (s == 10) begin
            chk("R10 period completes pulse", int'(pulse_valid), 1);
            chk("R10 period completes level", int'(pulse_amp), 50);
         end
         if (s >= 20)
            chk("R10 idle after stop", int'({period_start, pulse_valid, open_phase}), 0);
      end
      period_in = 12'd20;
      for (int s = 0; s < 11; s++) begin
         tick();
         if (s == 0) begin
            chk("R10 restart start", int'(period_start), 1);
            chk("R10 restart not second pulse", int'(pulse_valid), 0);
         end
         if (s == 10) chk("R10 restart first pulse level", int'(pulse_amp), 50);
      end

      // R11: no strobe, no change
      sample_en = 1'b0;
      for (int k = 0; k < 5; k++) begin
         tick();
         chk("R11 held pulse", int'(pulse_valid), 1);
         chk("R11 held level", int'(pulse_amp), 50);
      end
      sample_en = 1'b1;
      tick();
      chk("R11 resumes", int'(pulse_valid), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule